// File: doc/BRIEF.md
# Refresh Row Address Extender

This block sits beside a processor whose built-in refresh counter supplies only seven row-address bits, and in front of a DRAM array organised as 256 rows. The processor marks each refresh cycle by raising its refresh indicator together with its memory-request line. That happens in bus slots the processor does not otherwise need, such as during instruction decode. The block recognises those cycles, passes the seven processor bits straight through, and adds a top row bit of its own. That bit flips each time the processor's seven-bit count wraps, so the DRAM sees every one of its 256 rows in turn rather than only half of them.

A mode input selects a second address source: an internal row counter that advances once per refresh cycle and supplies all eight bits itself. Both sources share their progress, so a change of source between refresh cycles neither repeats nor skips a row. The outputs are the registered refresh row address and a refresh qualifier. The block also has a watchdog that measures the clock cycles between visits to row 0. It raises a flag when a full sweep takes longer than a parameterised budget, which by default is 64 ms at the configured clock.

Top module: `refresh_row_ext`

## Requirements
- R1: A refresh cycle is recognised only while `bus_refresh` and `bus_memreq` are both high. Either one alone leaves `row_strobe` low and `row_addr` unchanged.
- R2: In extend mode (`mode_sel` = 0) the issued row is {top bit, `cpu_row`}. The top bit flips on a refresh cycle whose `cpu_row` is numerically smaller than the `cpu_row` of the previous refresh cycle, as in 127 followed by 0. Reset clears the top bit and the remembered previous value to 0.
- R3: `row_strobe` goes high on the clock edge after a refresh cycle begins and stays high until the edge after it ends. It is low at all other times. The new `row_addr` appears on the same edge on which `row_strobe` rises.
- R4: Between refresh cycles `row_addr` holds the last issued row.
- R5: In counter mode (`mode_sel` = 1) the issued row is the internal counter. The counter moves up by one after each refresh cycle, wraps from 255 to 0, and is cleared to 0 by reset.
- R6: `mode_sel` is sampled only on clock edges where no refresh cycle is in progress. A change that is made and withdrawn within a refresh cycle has no effect.
- R7: A switch into counter mode continues from the row after the last one issued. The top bit keeps following the processor's wraps while counter mode is active, so a switch back to extend mode resumes the processor's sequence.
- R8: 256 consecutive extend-mode refresh cycles driven by a processor count that steps through its seven bits in order cover all 256 rows.
- R9: `interval_violation` goes high once `LIMIT_CYCLES` clock cycles have passed since row 0 was last issued (or since reset) without a new issue of row 0. It stays high until the edge that issues row 0, where it clears.
- R10: During and right after reset, `row_addr` is 0, and `row_strobe` and `interval_violation` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_refresh | input | 1 | Processor refresh indicator, active high |
| bus_memreq | input | 1 | Processor memory request, active high |
| mode_sel | input | 1 | Address source: 0 extend, 1 internal counter |
| cpu_row | input | ROW_W-1 | Processor refresh counter bits |
| row_addr | output | ROW_W | Refresh row address to the DRAM |
| row_strobe | output | 1 | High while the refresh row address is valid |
| interval_violation | output | 1 | Row 0 revisit budget exceeded |

## Verification
The bench targets three corner cases. The first is the 127-to-0 wrap of the processor count: a design that misses it issues only rows 0 to 127, so the coverage check finds half the rows never visited. The second is a source change in the middle of the sequence. A design that restarts its counter, or ignores the wraps that occur while the counter is the source, repeats or skips rows after the switch, and the scoreboard catches the mismatch on the first issued address. The bench also drives lone refresh or lone memory-request pulses, a mode flip made and withdrawn inside one cycle, and watchdog windows just short of and just past the budget. A design that reacts to either lone pulse, latches the mode mid-cycle, or miscounts the budget shows a strobe, an address or a flag that differs from the expected value.

// File: rtl/refresh_ext_pkg.sv
package refresh_ext_pkg;
    localparam int ROW_BITS = 8;

    typedef enum logic {
        SRC_EXTEND  = 1'b0,
        SRC_COUNTER = 1'b1
    } row_src_e;
endpackage

// File: rtl/refresh_cycle_detect.sv
module refresh_cycle_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic req_refresh,
    input  logic req_mem,
    output logic cyc_now,
    output logic cyc_start,
    output logic strobe
);
    typedef struct packed {
        logic active;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        cyc_now      = req_refresh & req_mem;
        st_d.active  = cyc_now;
        cyc_start    = cyc_now & ~st_q.active;
        strobe       = st_q.active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a cycle start is a single-cycle event
    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start);
endmodule

// File: rtl/row_source.sv
module row_source
    import refresh_ext_pkg::*;
#(
    parameter int ROW_W = ROW_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_now,
    input  logic             cyc_start,
    input  row_src_e         mode_in,
    input  logic [ROW_W-2:0] cpu_row,
    output logic [ROW_W-1:0] row_out,
    output logic [ROW_W-1:0] issue_row
);
    localparam int LOW_W = ROW_W - 1;

    typedef struct packed {
        logic             top;
        logic [LOW_W-1:0] last_low;
        logic [ROW_W-1:0] next_cnt;
        row_src_e         mode;
        logic [ROW_W-1:0] row;
    } src_state_t;

    src_state_t st_d, st_q;
    logic       wrap;
    logic       top_next;

    always_comb begin
        st_d     = st_q;
        wrap     = (cpu_row < st_q.last_low);
        top_next = st_q.top ^ wrap;
        if (st_q.mode == SRC_COUNTER) issue_row = st_q.next_cnt;
        else                          issue_row = {top_next, cpu_row};
        if (!cyc_now) st_d.mode = mode_in;
        if (cyc_start) begin
            st_d.top      = top_next;
            st_d.last_low = cpu_row;
            st_d.row      = issue_row;
            st_d.next_cnt = issue_row + 1'b1;
        end
        row_out = st_q.row;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= SRC_EXTEND;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: counter wraps from all-ones to zero
    p_cnt_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && st_q.mode == SRC_COUNTER && st_q.next_cnt == '1)
        |=> (st_q.row == '1 && st_q.next_cnt == '0));

    // R2: a processor wrap flips the top bit
    p_top_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && wrap) |=> (st_q.top != $past(st_q.top)));

    // R6: mode is frozen while a refresh cycle continues
    p_mode_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_now && $past(cyc_now)) |-> $stable(st_q.mode));
endmodule

// File: rtl/interval_watch.sv
module interval_watch #(
    parameter int unsigned LIMIT_CYCLES = 3200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_hit,
    output logic violation
);
    localparam int CW = $clog2(LIMIT_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT_CYCLES);

    typedef struct packed {
        logic [CW-1:0] elapsed;
    } wd_state_t;

    wd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (zero_hit)                 st_d.elapsed = '0;
        else if (st_q.elapsed != LIM) st_d.elapsed = st_q.elapsed + 1'b1;
        violation = (st_q.elapsed == LIM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: elapsed count saturates at the budget
    p_elapsed_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.elapsed <= LIM);

    // R9: issuing row 0 clears the flag on the next edge
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_hit |=> !violation);
endmodule

// File: rtl/refresh_row_ext.sv
module refresh_row_ext
    import refresh_ext_pkg::*;
#(
    parameter int          ROW_W        = ROW_BITS,
    parameter int unsigned CLK_HZ       = 50000000,
    parameter int unsigned INTERVAL_MS  = 64,
    parameter int unsigned LIMIT_CYCLES = CLK_HZ / 1000 * INTERVAL_MS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_refresh,
    input  logic             bus_memreq,
    input  logic             mode_sel,
    input  logic [ROW_W-2:0] cpu_row,
    output logic [ROW_W-1:0] row_addr,
    output logic             row_strobe,
    output logic             interval_violation
);
    logic             cyc_now;
    logic             cyc_start;
    logic [ROW_W-1:0] issue_row;
    logic             zero_hit;

    refresh_cycle_detect u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_refresh (bus_refresh),
        .req_mem     (bus_memreq),
        .cyc_now     (cyc_now),
        .cyc_start   (cyc_start),
        .strobe      (row_strobe)
    );

    row_source #(.ROW_W(ROW_W)) u_source (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_now   (cyc_now),
        .cyc_start (cyc_start),
        .mode_in   (row_src_e'(mode_sel)),
        .cpu_row   (cpu_row),
        .row_out   (row_addr),
        .issue_row (issue_row)
    );

    assign zero_hit = cyc_start && (issue_row == '0);

    interval_watch #(.LIMIT_CYCLES(LIMIT_CYCLES)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_hit  (zero_hit),
        .violation (interval_violation)
    );

    // R4: the address moves only together with a rising qualifier
    p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(row_strobe) |-> $stable(row_addr));

    // R1: without the refresh indicator no qualifier follows
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_refresh |=> !row_strobe);
endmodule

// File: tb/refresh_row_ext_bench.sv
`timescale 1ns/1ps
module refresh_row_ext_bench;
    localparam int LIMIT = 2000;

    typedef struct {
        logic [7:0] row;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_refresh;
    logic       bus_memreq;
    logic       mode_sel;
    logic [6:0] cpu_row;
    logic [7:0] row_addr;
    logic       row_strobe;
    logic       interval_violation;

    always #10 clk = ~clk;

    refresh_row_ext #(.ROW_W(8), .LIMIT_CYCLES(LIMIT)) u_refresh_row_ext (
        .clk                (clk),
        .rst_n              (rst_n),
        .bus_refresh        (bus_refresh),
        .bus_memreq         (bus_memreq),
        .mode_sel           (mode_sel),
        .cpu_row            (cpu_row),
        .row_addr           (row_addr),
        .row_strobe         (row_strobe),
        .interval_violation (interval_violation)
    );

    int         checks = 0;
    int         failures = 0;
    exp_t       expq[$];
    logic       m_top = 1'b0;
    logic [6:0] m_last = '0;
    logic [7:0] m_next = '0;
    logic       m_mode = 1'b0;
    logic [6:0] cpu_ctr = '0;
    logic [7:0] last_issued = '0;
    bit         seen[256];
    logic       prev_strobe = 1'b0;
    bit         done = 1'b0;
    string      tag = "R2";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops an expected row on every rising qualifier
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (row_strobe && !prev_strobe) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R1", "unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(row_addr == e.row, e.req, "row_addr", row_addr, e.row);
                    seen[row_addr] = 1'b1;
                end
            end
            prev_strobe = row_strobe;
        end
    end

    task automatic refresh(input bit glitch);
        logic       wrap;
        logic [7:0] issued;
        exp_t       e;
        wrap   = (cpu_ctr < m_last);
        m_top  = m_top ^ wrap;
        issued = m_mode ? m_next : {m_top, cpu_ctr};
        m_last = cpu_ctr;
        m_next = issued + 8'd1;
        e.row  = issued;
        e.req  = tag;
        expq.push_back(e);
        bus_refresh = 1'b1;
        bus_memreq  = 1'b1;
        cpu_row     = cpu_ctr;
        @(negedge clk);
        if (glitch) mode_sel = ~m_mode;   // R6: flipped inside the cycle
        @(negedge clk);
        bus_refresh = 1'b0;
        bus_memreq  = 1'b0;
        mode_sel    = m_mode;
        cpu_ctr     = cpu_ctr + 7'd1;
        @(negedge clk);
        chk(row_strobe == 1'b0, "R3", "strobe after cycle", row_strobe, 0);
        chk(row_addr == issued, "R4", "addr held", row_addr, issued);
        last_issued = issued;
        @(negedge clk);
    endtask

    task automatic stray(input logic r, input logic m);
        bus_refresh = r;
        bus_memreq  = m;
        repeat (2) begin
            @(negedge clk);
            chk(row_strobe == 1'b0, "R1", "strobe on lone signal", row_strobe, 0);
        end
        bus_refresh = 1'b0;
        bus_memreq  = 1'b0;
        @(negedge clk);
        chk(row_addr == last_issued, "R1", "addr on lone signal", row_addr, last_issued);
    endtask

    task automatic set_mode(input logic v);
        mode_sel = v;
        m_mode   = v;
        @(negedge clk);
    endtask

    task automatic refresh_until_zero();
        while (m_next != 8'd0) refresh(1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        bus_refresh = 1'b0;
        bus_memreq  = 1'b0;
        mode_sel    = 1'b0;
        cpu_row     = '0;
        repeat (4) @(negedge clk);
        chk(row_addr == 8'd0, "R10", "reset addr", row_addr, 0);
        chk(row_strobe == 1'b0, "R10", "reset strobe", row_strobe, 0);
        chk(interval_violation == 1'b0, "R10", "reset flag", interval_violation, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // extend mode sweep with coverage
        foreach (seen[i]) seen[i] = 1'b0;
        tag = "R2";
        for (int i = 0; i < 256; i++) refresh(1'b0);
        begin
            int miss = 0;
            foreach (seen[i]) if (!seen[i]) miss++;
            chk(miss == 0, "R8", "rows not covered", miss, 0);
        end
        for (int i = 0; i < 44; i++) refresh(1'b0);
        chk(interval_violation == 1'b0, "R9", "flag during sweep", interval_violation, 0);

        // lone control signals
        stray(1'b1, 1'b0);
        stray(1'b0, 1'b1);

        // mode flip withdrawn inside a cycle
        tag = "R6";
        refresh(1'b1);
        refresh(1'b0);

        // switch to counter mode, including the 255 to 0 wrap
        set_mode(1'b1);
        tag = "R7";
        refresh(1'b0);
        tag = "R5";
        for (int i = 0; i < 300; i++) refresh(1'b0);

        // back to extend mode
        set_mode(1'b0);
        tag = "R7";
        for (int i = 0; i < 20; i++) refresh(1'b0);

        // interval watchdog
        set_mode(1'b1);
        tag = "R5";
        refresh_until_zero();
        refresh(1'b0);
        repeat (LIMIT - 10) @(negedge clk);
        chk(interval_violation == 1'b0, "R9", "flag before budget", interval_violation, 0);
        repeat (15) @(negedge clk);
        chk(interval_violation == 1'b1, "R9", "flag past budget", interval_violation, 1);
        repeat (100) @(negedge clk);
        chk(interval_violation == 1'b1, "R9", "flag stays high", interval_violation, 1);
        refresh_until_zero();
        chk(interval_violation == 1'b1, "R9", "flag before row 0", interval_violation, 1);
        refresh(1'b0);
        chk(interval_violation == 1'b0, "R9", "flag after row 0", interval_violation, 0);

        chk(expq.size() == 0, "R3", "pending rows", expq.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule